// File: doc/BRIEF.md
# Write-behind cache controller

This block is a direct-mapped data cache controller placed between a processor request port and a slow main-memory port. Its policy is write-through with write-behind. Every store is forwarded to memory, so memory always holds the newest value of every word. The processor does not wait for that memory write to finish: an accepted store sits in a one-entry holding register and drains to memory in the background while the processor carries on.

Each line holds a single word, with one valid bit and one tag. A load that hits is answered in the cycle it is presented. A load that misses fetches its word from memory and fills the line. If a store is still draining when a miss arrives, the miss waits for that memory write to complete, then issues its own fill read, and the processor stays stalled until the fill is done. Stores that miss do not allocate a line.

The processor port uses a valid/ready handshake, and the processor holds its request stable until ready. The memory port carries one request at a time, held until a one-cycle done pulse comes back after any latency.

Top module: `wtb_cache`

## Requirements
- R1: Each accepted store causes exactly one memory write with the same address and data. These writes reach memory in the order the stores were accepted, so memory finally holds the newest value of every word.
- R2: A store presented while the holding register is empty is accepted in that same cycle (cpu_ready high), whatever the memory is doing.
- R3: The holding register holds one store. A store presented while an earlier store has not yet seen its memory done keeps cpu_ready low, and is accepted from the cycle after that done onward.
- R4: A store that hits replaces the cached word in its acceptance cycle. A later load of that address returns the stored value without a memory read.
- R5: A store that misses leaves the cache unchanged (no allocate). A later load of that address misses and issues a memory read.
- R6: A load that hits completes in the cycle it is presented, even while a store is still draining.
- R7: When a load misses while a store is draining, the fill read (mem_we low) is issued only after that write's done, and it carries the missed address.
- R8: A load that misses keeps cpu_ready low until its fill read's done. It is accepted in the following cycle with the data the fill returned, and its line becomes valid. The line is selected by the low log2(LINES) bits of the word address; the remaining bits form the tag.
- R9: Synchronous active-high rst clears every valid bit and issues no memory request. The first load of any address after reset misses.
- R10: mem_req stays high with mem_addr and mem_we stable until mem_done. It falls in the cycle after mem_done, and only one request is ever outstanding.
- R11: Any memory latency of one cycle or more, varying from request to request, gives the same results at both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_rdata | output | DATA_W | Load data, valid when a load is accepted |
| mem_req | output | 1 | Memory request, held until mem_done |
| mem_we | output | 1 | 1 = memory write, 0 = fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Fill data, valid with mem_done |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
A wrong valid bit or tag shows up at cpu_ready the first time that index is presented. A hit would be acknowledged in zero cycles where a miss was due, or a fill read would appear where none belongs, and the load data would differ from the newest stored value. A holding register that loses or duplicates a store shows up at the memory port as soon as that write completes: the address and data are compared with the oldest unfinished store, and memory is compared word by word at the end. A fill issued before a pending write has drained is caught on the cycle mem_req rises for the read.

// File: rtl/wtb_pkg.sv
package wtb_pkg;

    // Memory-port sequencer phases.
    typedef enum logic [1:0] {
        MP_IDLE   = 2'd0,
        MP_DRAIN  = 2'd1,
        MP_REFILL = 2'd2
    } mport_state_e;

    // Processor operation kind, decoded from cpu_we.
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } cpu_op_e;

endpackage

// File: rtl/wtb_line_store.sv
module wtb_line_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    // lookup / store-hit port
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              st_we,
    input  logic [DATA_W-1:0] st_data,
    // fill port
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] fill_idx;
    logic [TAG_W-1:0] fill_tag;

    assign lk_idx   = lk_addr[IDX_W-1:0];
    assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
    assign fill_idx = fill_addr[IDX_W-1:0];
    assign fill_tag = fill_addr[ADDR_W-1:IDX_W];

    logic [LINES-1:0] valid_vec;
    logic [TAG_W-1:0] tag_arr  [LINES];
    logic [DATA_W-1:0] data_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              fill_sel;
        logic              st_sel;

        assign fill_sel = fill_we && (fill_idx == IDX_W'(g));
        assign st_sel   = st_we && (lk_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (fill_sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_sel) begin
                t_q <= fill_tag;
                d_q <= fill_data;
            end else if (st_sel) begin
                d_q <= st_data;
            end
        end

        assign valid_vec[g] = v_q;
        assign tag_arr[g]   = t_q;
        assign data_arr[g]  = d_q;
    end

    assign lk_hit  = valid_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);
    assign lk_data = data_arr[lk_idx];

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> valid_vec[$past(fill_idx)]);  // R8

    AST_RESET_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));  // R9

endmodule

// File: rtl/wtb_store_buffer.sv
module wtb_store_buffer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drain,
    output logic              full,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
        end else if (drain) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            buf_addr <= load_addr;
            buf_data <= load_data;
        end
    end

    AST_WB_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        load |-> !full);  // R3

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (full && !drain) |=> (full && $stable(buf_addr) && $stable(buf_data)));  // R1

endmodule

// File: rtl/wtb_mem_sequencer.sv
module wtb_mem_sequencer
    import wtb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_full,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              miss_req,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_done,
    output logic              drain_done,
    output logic              fill_done,
    output logic              refill_busy,
    output logic [ADDR_W-1:0] fill_addr
);
    mport_state_e      state_q, state_d;
    logic [ADDR_W-1:0] rd_addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MP_IDLE: begin
                if (buf_full) begin
                    state_d = MP_DRAIN;     // pending store always goes first
                end else if (miss_req) begin
                    state_d = MP_REFILL;
                end
            end
            MP_DRAIN:  if (mem_done) state_d = MP_IDLE;
            MP_REFILL: if (mem_done) state_d = MP_IDLE;
            default:   state_d = MP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr_q <= '0;
        end else if (state_q == MP_IDLE && !buf_full && miss_req) begin
            rd_addr_q <= miss_addr;
        end
    end

    assign mem_req     = (state_q != MP_IDLE);
    assign mem_we      = (state_q == MP_DRAIN);
    assign mem_addr    = (state_q == MP_DRAIN) ? buf_addr : rd_addr_q;
    assign mem_wdata   = buf_data;
    assign drain_done  = (state_q == MP_DRAIN) && mem_done;
    assign fill_done   = (state_q == MP_REFILL) && mem_done;
    assign refill_busy = (state_q == MP_REFILL);
    assign fill_addr   = rd_addr_q;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_done) |=> !mem_req);  // R10

    AST_FILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !buf_full);  // R7

endmodule

// File: rtl/wtb_cache.sv
module wtb_cache
    import wtb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done
);
    cpu_op_e           op;
    logic              hit;
    logic [DATA_W-1:0] line_data;
    logic              buf_full;
    logic [ADDR_W-1:0] buf_addr;
    logic [DATA_W-1:0] buf_data;
    logic              drain_done;
    logic              fill_done;
    logic              refill_busy;
    logic [ADDR_W-1:0] fill_addr;
    logic              store_acc;
    logic              store_hit;
    logic              miss_req;

    assign op        = cpu_op_e'(cpu_we);
    assign store_acc = cpu_valid && (op == OP_STORE) && !buf_full;
    assign store_hit = store_acc && hit;
    assign miss_req  = cpu_valid && (op == OP_LOAD) && !hit;
    assign cpu_ready = cpu_valid && ((op == OP_STORE) ? !buf_full : hit);
    assign cpu_rdata = line_data;

    wtb_line_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LINES  (LINES)
    ) u_lines (
        .clk       (clk),
        .rst       (rst),
        .lk_addr   (cpu_addr),
        .lk_hit    (hit),
        .lk_data   (line_data),
        .st_we     (store_hit),
        .st_data   (cpu_wdata),
        .fill_we   (fill_done),
        .fill_addr (fill_addr),
        .fill_data (mem_rdata)
    );

    wtb_store_buffer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .load      (store_acc),
        .load_addr (cpu_addr),
        .load_data (cpu_wdata),
        .drain     (drain_done),
        .full      (buf_full),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data)
    );

    wtb_mem_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .buf_full    (buf_full),
        .buf_addr    (buf_addr),
        .buf_data    (buf_data),
        .miss_req    (miss_req),
        .miss_addr   (cpu_addr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_done    (mem_done),
        .drain_done  (drain_done),
        .fill_done   (fill_done),
        .refill_busy (refill_busy),
        .fill_addr   (fill_addr)
    );

    AST_MISS_HELD: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && !cpu_we && refill_busy) |-> !cpu_ready);  // R8

    AST_NO_REQ_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_req);  // R9

endmodule

// File: tb/wtb_cache_bench.sv
module wtb_cache_bench;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;
    localparam int LINES     = 16;
    localparam int IDX_W     = 4;
    localparam int MEM_WORDS = 256;
    localparam int N_RANDOM  = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;  // 50 MHz

    logic              cpu_valid = 1'b0;
    logic              cpu_we    = 1'b0;
    logic [ADDR_W-1:0] cpu_addr  = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_done  = 1'b0;

    wtb_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_wtb_cache (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [DATA_W-1:0] mem_img [MEM_WORDS];   // the memory itself
    logic [DATA_W-1:0] arch    [MEM_WORDS];   // newest value per word
    bit                ref_valid [LINES];
    logic [ADDR_W-IDX_W-1:0] ref_tag [LINES];
    int                pend = 0;              // stores not yet retired by memory
    logic [ADDR_W-1:0] wq_addr [$];
    logic [DATA_W-1:0] wq_data [$];

    function automatic logic [DATA_W-1:0] init_val(int a);
        return (DATA_W'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Memory model: random latency, responds on the falling edge.
    initial begin
        bit                busy = 0;
        bit                l_we = 0;
        int                cnt  = 0;
        logic [ADDR_W-1:0] l_addr = '0;
        logic [DATA_W-1:0] l_data = '0;
        forever begin
            @(negedge clk);
            if (mem_done) begin
                // the design saw done on the last rising edge
                mem_done = 1'b0;
                check(mem_req == 1'b0, "R10", "request still high after done", longint'(mem_req), 0);
                if (l_we) begin
                    pend--;
                end else begin
                    ref_valid[int'(l_addr) % LINES] = 1;
                    ref_tag[int'(l_addr) % LINES]   = l_addr[ADDR_W-1:IDX_W];
                end
            end else if (rst) begin
                busy = 0;
            end else if (busy) begin
                check(mem_req && mem_addr == l_addr && mem_we == l_we &&
                      (!l_we || mem_wdata == l_data),
                      "R11", "request changed while waiting", longint'(mem_addr), longint'(l_addr));
                cnt--;
                if (cnt == 0) begin
                    busy = 0;
                    mem_done = 1'b1;
                    if (l_we) begin
                        if (wq_addr.size() == 0) begin
                            check(0, "R1", "memory write with no store outstanding", longint'(l_addr), 0);
                        end else begin
                            check(l_addr == wq_addr[0] && l_data == wq_data[0], "R1",
                                  "memory write differs from oldest store",
                                  {16'h0, l_addr, l_data[15:0]}, {16'h0, wq_addr[0], wq_data[0][15:0]});
                            void'(wq_addr.pop_front());
                            void'(wq_data.pop_front());
                        end
                        mem_img[int'(l_addr)] = l_data;
                    end else begin
                        mem_rdata = mem_img[int'(l_addr)];
                    end
                end
            end else if (mem_req) begin
                busy   = 1;
                l_we   = mem_we;
                l_addr = mem_addr;
                l_data = mem_wdata;
                cnt    = int'($urandom_range(1, 6));
                check(int'(mem_addr) < MEM_WORDS, "R10", "address out of range", longint'(mem_addr), 0);
                if (!mem_we) begin
                    check(pend == 0, "R7", "fill read while store pending", longint'(pend), 0);
                    check(mem_addr == cpu_addr && cpu_valid && !cpu_we, "R7", "fill address",
                          longint'(mem_addr), longint'(cpu_addr));
                end
            end
        end
    end

    // One processor request; returns the number of stalled cycles.
    task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, output int waits);
        int  idx = int'(a) % LINES;
        bit  exp_rdy;
        string tag;
        waits = 0;
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        forever begin
            #1;
            if (we) begin
                exp_rdy = (pend == 0);
                tag = (pend == 0) ? "R2" : "R3";
            end else begin
                exp_rdy = ref_valid[idx] && (ref_tag[idx] == a[ADDR_W-1:IDX_W]);
                tag = !exp_rdy ? "R8" : ((pend != 0) ? "R6" : "R4");
            end
            check(cpu_ready == exp_rdy, tag, "cpu_ready", longint'(cpu_ready), longint'(exp_rdy));
            if (cpu_ready) break;
            waits++;
            @(negedge clk);
        end
        if (we) begin
            arch[int'(a)] = d;
            pend++;
            wq_addr.push_back(a);
            wq_data.push_back(d);
        end else begin
            check(cpu_rdata == arch[int'(a)], waits > 0 ? "R8" : "R4", "load data",
                  longint'(cpu_rdata), longint'(arch[int'(a)]));
        end
        @(posedge clk);
        #1;
        cpu_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int w;
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem_img[i] = init_val(i);
            arch[i]    = init_val(i);
        end
        for (int i = 0; i < LINES; i++) begin
            ref_valid[i] = 0;
            ref_tag[i]   = '0;
        end
        repeat (4) @(negedge clk);
        check(mem_req == 1'b0, "R9", "mem_req in reset", longint'(mem_req), 0);
        rst = 1'b0;

        // Directed sequence. Index = low 4 bits, so 0x10 and 0x20 share line 0.
        cpu_op(0, 16'h0010, '0, w);
        check(w > 0, "R9", "first load after reset should miss", longint'(w), 1);
        cpu_op(0, 16'h0010, '0, w);
        check(w == 0, "R8", "filled line should hit", longint'(w), 0);
        cpu_op(1, 16'h0010, 32'hCAFE0001, w);
        check(w == 0, "R2", "store to empty register stalled", longint'(w), 0);
        cpu_op(0, 16'h0010, '0, w);
        check(w == 0, "R6", "hit load during drain stalled", longint'(w), 0);
        cpu_op(1, 16'h0020, 32'hBEEF0002, w);
        cpu_op(0, 16'h0020, '0, w);
        check(w > 0, "R5", "load after store miss should miss", longint'(w), 1);
        cpu_op(0, 16'h0010, '0, w);
        check(w > 0, "R8", "conflicting line should miss", longint'(w), 1);
        cpu_op(1, 16'h0031, 32'h0000AAAA, w);
        cpu_op(1, 16'h0032, 32'h0000BBBB, w);
        check(w > 0, "R3", "second store while first pending", longint'(w), 1);

        // Random loads and stores with random memory latency.
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom_range(0, 63));
            if ($urandom_range(0, 1) == 1) begin
                cpu_op(1, a, DATA_W'($urandom), w);
            end else begin
                cpu_op(0, a, '0, w);
            end
        end

        while (pend != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(wq_addr.size() == 0, "R1", "stores never written", longint'(wq_addr.size()), 0);
        for (int i = 0; i < MEM_WORDS; i++) begin
            check(mem_img[i] == arch[i], "R1", "final memory word",
                  longint'(mem_img[i]), longint'(arch[i]));
        end
        finish_run();
    end

endmodule